// File: doc/BRIEF.md
# SPI Command Register Interface

This block is the serial host port of a CAN controller. A host acting as SPI master (mode 0, most significant bit first) opens a frame by pulling chip select low, sends a one-byte opcode and then either data bytes or dummy bytes while it clocks reply bytes back on MISO. The opcode picks one of a fixed set of actions: write or read one of the byte-wide control registers, read the live status byte, read and clear the sticky error and interrupt flag bytes, restart the register file, or move a burst of frame bytes between the host and the receive or transmit FIFO ports.

The protocol engine, bit timing and FIFO storage sit outside. The engine drives status levels and one-cycle set pulses for error and interrupt flags. The receive FIFO offers its head byte together with an empty flag and takes a pop pulse. The transmit FIFO takes a byte with a push pulse. The serial pins are sampled into the system clock domain, so SCLK must be slow compared with the system clock: each SCLK half period should last at least ten system clocks.

Top module: `spi_cmd_regif`

## Requirements
- R1: After system reset, control register 0 reads 0x80, so the mode output (bits 7:5) is 4 for initialisation. Control register 1 and the interrupt enables read 0x00, and the interrupt output is low.
- R2: A two-byte frame made of a write opcode and a data byte stores the data byte in the register: 0x14 for control 0, 0x16 for control 1, 0x1C for the interrupt enables. The mode output is control 0 bits 7:5, the transmit enable output is control 1 bit 7, and the enable output is the enable register.
- R3: A two-byte frame made of a read opcode and a dummy byte returns the register value, MSB first, during the second byte: 0xD2 for control 0, 0xD4 for control 1, 0xE2 for status. The status byte is built from live inputs with bit 7 TX FIFO empty, bit 4 error warning, bit 3 error passive, bit 2 bus off, bit 1 RX FIFO empty and the other bits zero, so it reads 0x82 when idle.
- R4: Opcode 0x56 completed as the first byte restores control 0 to 0x80 and clears control 1, the interrupt enables and the interrupt flags. It leaves the error flags unchanged.
- R5: Each bit of the error register (bit 7 bus off, 6 TX passive, 5 RX passive, 4 bit, 3 form, 2 CRC, 1 ack, 0 stuff) is set by a pulse on the matching error-set bit and stays set. A completed 0xDC read returns the flags and clears only the bits it returned. A set pulse wins over a clear in the same cycle.
- R6: Interrupt flags are set by pulses in the same way. A completed 0xDE read returns them and clears the bits it returned. The interrupt output is high whenever a flag is set and its enable bit is also set.
- R7: Opcode 0x48 returns receive FIFO bytes on the up to 14 bytes that follow it. Each such byte, once fully clocked out, pops the FIFO once. No pop is issued while the FIFO is empty, and those byte slots, like any byte past the fourteenth, return 0x00.
- R8: Opcode 0x12 pushes each fully received data byte into the transmit FIFO, up to 14 bytes per frame. Any further bytes are dropped.
- R9: Raising chip select before a byte is complete discards that byte. An aborted write leaves the register unchanged, and an aborted flag read clears nothing.
- R10: An unknown opcode returns 0x00 on every byte of the frame and changes no register, flag or FIFO.
- R11: MISO is driven low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | Chip select, active low, frames a command |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| st_tx_empty | input | 1 | Transmit FIFO empty level |
| st_rx_empty | input | 1 | Receive FIFO empty level |
| st_bus_off | input | 1 | Engine bus-off level |
| st_err_pass | input | 1 | Engine error-passive level |
| st_err_warn | input | 1 | Engine error-warning level |
| err_set | input | 8 | One-cycle pulses that set error flags |
| irq_set | input | 8 | One-cycle pulses that set interrupt flags |
| rx_data | input | 8 | Head byte of the receive FIFO |
| rx_pop | output | 1 | Pop pulse to the receive FIFO |
| tx_data | output | 8 | Byte for the transmit FIFO |
| tx_push | output | 1 | Push pulse to the transmit FIFO |
| mode_o | output | 3 | Operating mode field of control 0 |
| tx_en_o | output | 1 | Transmit enable from control 1 |
| int_en_o | output | 8 | Interrupt enable register |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 14-byte burst limit and two synchroniser stages, with SCLK half periods of ten system clocks. At these values, 16- and 17-byte bursts cross the burst limit in both directions. A receive FIFO holding 16 bytes lets one burst hit the limit and the next one run the FIFO dry partway through. Aborts placed four bits into the second byte exercise the point where a write or a read-to-clear would otherwise commit.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int BYTE_W = 8;

  localparam logic [7:0] OP_RESET   = 8'h56;
  localparam logic [7:0] OP_RD_CTL0 = 8'hD2;
  localparam logic [7:0] OP_RD_CTL1 = 8'hD4;
  localparam logic [7:0] OP_RD_STAT = 8'hE2;
  localparam logic [7:0] OP_WR_CTL0 = 8'h14;
  localparam logic [7:0] OP_WR_CTL1 = 8'h16;
  localparam logic [7:0] OP_WR_IEN  = 8'h1C;
  localparam logic [7:0] OP_RD_IFLG = 8'hDE;
  localparam logic [7:0] OP_RD_ERR  = 8'hDC;
  localparam logic [7:0] OP_RD_FIFO = 8'h48;
  localparam logic [7:0] OP_WR_FIFO = 8'h12;

  localparam logic [7:0] CTL0_INIT = 8'h80;

  typedef enum logic [3:0] {
    CMD_NONE, CMD_RESET, CMD_RD_CTL0, CMD_RD_CTL1, CMD_RD_STAT,
    CMD_WR_CTL0, CMD_WR_CTL1, CMD_WR_IEN, CMD_RD_IFLG, CMD_RD_ERR,
    CMD_RD_FIFO, CMD_WR_FIFO
  } cmd_e;

  function automatic cmd_e decode_op(input logic [7:0] op);
    case (op)
      OP_RESET:   return CMD_RESET;
      OP_RD_CTL0: return CMD_RD_CTL0;
      OP_RD_CTL1: return CMD_RD_CTL1;
      OP_RD_STAT: return CMD_RD_STAT;
      OP_WR_CTL0: return CMD_WR_CTL0;
      OP_WR_CTL1: return CMD_WR_CTL1;
      OP_WR_IEN:  return CMD_WR_IEN;
      OP_RD_IFLG: return CMD_RD_IFLG;
      OP_RD_ERR:  return CMD_RD_ERR;
      OP_RD_FIFO: return CMD_RD_FIFO;
      OP_WR_FIFO: return CMD_WR_FIFO;
      default:    return CMD_NONE;
    endcase
  endfunction
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic mosi_s
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] sclk_q, cs_q, mosi_q;
  logic         sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_q <= {sclk_q[TOP-1:0], sclk_i};
      cs_q   <= {cs_q[TOP-1:0], cs_n_i};
      mosi_q <= {mosi_q[TOP-1:0], mosi_i};
      sclk_d <= sclk_q[TOP];
    end
  end

  assign sclk_rise = sclk_q[TOP] & ~sclk_d;
  assign sclk_fall = ~sclk_q[TOP] & sclk_d;
  assign cs_act    = ~cs_q[TOP];
  assign mosi_s    = mosi_q[TOP];
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_act,
  input  logic          sclk_rise,
  input  logic          sclk_fall,
  input  logic          mosi_s,
  input  logic          load,
  input  logic [DW-1:0] load_byte,
  output logic          byte_done,
  output logic [DW-1:0] rx_byte,
  output logic          miso
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [CW-1:0] bit_cnt;
  logic [DW-1:0] rx_sr, tx_sr;

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      bit_cnt   <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      byte_done <= 1'b0;
      if (rst) rx_byte <= '0;
    end else begin
      byte_done <= 1'b0;
      if (sclk_rise) begin
        rx_sr   <= {rx_sr[DW-2:0], mosi_s};
        bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
        if (bit_cnt == LAST) begin
          byte_done <= 1'b1;
          rx_byte   <= {rx_sr[DW-2:0], mosi_s};
        end
      end
      // The falling edge that closes a byte keeps the freshly loaded MSB
      if (load) tx_sr <= load_byte;
      else if (sclk_fall && bit_cnt != '0) tx_sr <= {tx_sr[DW-2:0], 1'b0};
    end
  end

  assign miso = tx_sr[DW-1];
endmodule

// File: rtl/spi_reg_core.sv
module spi_reg_core
  import spi_cmd_pkg::*;
#(
  parameter int FRAME_BYTES = 14
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_act,
  input  logic       byte_done,
  input  logic [7:0] rx_byte,
  input  logic       st_tx_empty,
  input  logic       st_rx_empty,
  input  logic       st_bus_off,
  input  logic       st_err_pass,
  input  logic       st_err_warn,
  input  logic [7:0] err_set,
  input  logic [7:0] irq_set,
  input  logic [7:0] rx_data,
  output logic       load,
  output logic [7:0] load_byte,
  output logic       rx_pop,
  output logic [7:0] tx_data,
  output logic       tx_push,
  output logic [7:0] ctl0,
  output logic [7:0] ctl1,
  output logic [7:0] ien,
  output logic [7:0] iflg,
  output logic [7:0] eflg
);
  localparam int IDXW = $clog2(FRAME_BYTES + 2);
  localparam logic [IDXW-1:0] MAXIDX = IDXW'(FRAME_BYTES + 1);

  cmd_e            cmd, op_cmd;
  logic [IDXW-1:0] bidx;
  logic [1:0]      ld_cnt;
  logic [7:0]      snap, resp, status_b, clr_e, clr_i;

  function automatic logic in_frame(input logic [IDXW-1:0] i);
    return (i != '0) && (int'(i) <= FRAME_BYTES);
  endfunction

  assign op_cmd   = decode_op(rx_byte);
  assign status_b = {st_tx_empty, 2'b00, st_err_warn, st_err_pass, st_bus_off, st_rx_empty, 1'b0};

  always_comb begin
    resp = 8'h00;
    if (bidx == IDXW'(1)) begin
      case (cmd)
        CMD_RD_CTL0: resp = ctl0;
        CMD_RD_CTL1: resp = ctl1;
        CMD_RD_STAT: resp = status_b;
        CMD_RD_ERR:  resp = eflg;
        CMD_RD_IFLG: resp = iflg;
        default:     resp = 8'h00;
      endcase
    end
    if (cmd == CMD_RD_FIFO && in_frame(bidx) && !st_rx_empty) resp = rx_data;
  end

  always_comb begin
    clr_e = 8'h00;
    clr_i = 8'h00;
    if (cs_act && byte_done && bidx == IDXW'(1)) begin
      if (cmd == CMD_RD_ERR)  clr_e = snap;
      if (cmd == CMD_RD_IFLG) clr_i = snap;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl0 <= CTL0_INIT; ctl1 <= '0; ien <= '0; iflg <= '0; eflg <= '0;
      cmd <= CMD_NONE; bidx <= '0; ld_cnt <= '0; snap <= '0;
      load <= 1'b0; load_byte <= '0; rx_pop <= 1'b0; tx_push <= 1'b0; tx_data <= '0;
    end else begin
      load    <= 1'b0;
      rx_pop  <= 1'b0;
      tx_push <= 1'b0;
      eflg    <= (eflg & ~clr_e) | err_set;
      iflg    <= (iflg & ~clr_i) | irq_set;
      if (!cs_act) begin
        cmd    <= CMD_NONE;
        bidx   <= '0;
        ld_cnt <= '0;
      end else begin
        if (ld_cnt != 2'd0) ld_cnt <= ld_cnt - 2'd1;
        if (ld_cnt == 2'd1) begin
          load      <= 1'b1;
          load_byte <= resp;
          snap      <= resp;
        end
        if (byte_done) begin
          ld_cnt <= 2'd2;
          if (bidx != MAXIDX) bidx <= bidx + 1'b1;
          if (bidx == '0) begin
            cmd <= op_cmd;
            if (op_cmd == CMD_RESET) begin
              ctl0 <= CTL0_INIT;
              ctl1 <= '0;
              ien  <= '0;
              iflg <= irq_set;
            end
          end else if (bidx == IDXW'(1)) begin
            case (cmd)
              CMD_WR_CTL0: ctl0 <= rx_byte;
              CMD_WR_CTL1: ctl1 <= rx_byte;
              CMD_WR_IEN:  ien  <= rx_byte;
              default: ;
            endcase
          end
          if (cmd == CMD_WR_FIFO && in_frame(bidx)) begin
            tx_push <= 1'b1;
            tx_data <= rx_byte;
          end
          if (cmd == CMD_RD_FIFO && in_frame(bidx) && !st_rx_empty) rx_pop <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_cmd_regif.sv
module spi_cmd_regif #(
  parameter int FRAME_BYTES = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       spi_sclk,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  output logic       spi_miso,
  input  logic       st_tx_empty,
  input  logic       st_rx_empty,
  input  logic       st_bus_off,
  input  logic       st_err_pass,
  input  logic       st_err_warn,
  input  logic [7:0] err_set,
  input  logic [7:0] irq_set,
  input  logic [7:0] rx_data,
  output logic       rx_pop,
  output logic [7:0] tx_data,
  output logic       tx_push,
  output logic [2:0] mode_o,
  output logic       tx_en_o,
  output logic [7:0] int_en_o,
  output logic       irq_o
);
  logic       sclk_rise, sclk_fall, cs_act, mosi_s;
  logic       byte_done, ld, shift_miso;
  logic [7:0] rx_byte, ld_byte;
  logic [7:0] ctl0, ctl1, ien, iflg, err_flags;

  spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk_i(spi_sclk), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act), .mosi_s(mosi_s)
  );

  spi_byte_shifter #(.DW(spi_cmd_pkg::BYTE_W)) u_shift (
    .clk(clk), .rst(rst), .cs_act(cs_act), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .mosi_s(mosi_s), .load(ld), .load_byte(ld_byte), .byte_done(byte_done),
    .rx_byte(rx_byte), .miso(shift_miso)
  );

  spi_reg_core #(.FRAME_BYTES(FRAME_BYTES)) u_core (
    .clk(clk), .rst(rst), .cs_act(cs_act), .byte_done(byte_done), .rx_byte(rx_byte),
    .st_tx_empty(st_tx_empty), .st_rx_empty(st_rx_empty), .st_bus_off(st_bus_off),
    .st_err_pass(st_err_pass), .st_err_warn(st_err_warn), .err_set(err_set),
    .irq_set(irq_set), .rx_data(rx_data), .load(ld), .load_byte(ld_byte),
    .rx_pop(rx_pop), .tx_data(tx_data), .tx_push(tx_push), .ctl0(ctl0), .ctl1(ctl1),
    .ien(ien), .iflg(iflg), .eflg(err_flags)
  );

  assign spi_miso = shift_miso;
  assign mode_o   = ctl0[7:5];
  assign tx_en_o  = ctl1[7];
  assign int_en_o = ien;
  assign irq_o    = |(iflg & ien);
endmodule

// File: rtl/spi_cmd_regif_chk.sv
module spi_cmd_regif_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_act,
  input logic       spi_miso,
  input logic       rx_pop,
  input logic       tx_push,
  input logic       st_rx_empty,
  input logic [7:0] err_set,
  input logic [7:0] err_flags
);
  AST_POP_SINGLE: assert property (@(posedge clk) disable iff (rst) rx_pop |=> !rx_pop); // R7
  AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst) rx_pop |-> $past(!st_rx_empty)); // R7
  AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (rst) tx_push |=> !tx_push); // R8
  AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (rst) !(rx_pop && tx_push)); // R8
  AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|err_set) |=> ((err_flags & $past(err_set)) == $past(err_set))); // R5
  AST_IDLE_NO_FIFO: assert property (@(posedge clk) disable iff (rst) !cs_act |=> (!rx_pop && !tx_push)); // R9
  AST_MISO_IDLE: assert property (@(posedge clk) disable iff (rst) !cs_act |=> !spi_miso); // R11
endmodule

bind spi_cmd_regif spi_cmd_regif_chk u_chk (
  .clk(clk), .rst(rst), .cs_act(cs_act), .spi_miso(spi_miso), .rx_pop(rx_pop),
  .tx_push(tx_push), .st_rx_empty(st_rx_empty), .err_set(err_set), .err_flags(err_flags)
);

// File: tb/spi_cmd_regif_bench.sv
module spi_cmd_regif_bench;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso;
  logic st_tx_empty = 1'b1, st_bus_off = 1'b0, st_err_pass = 1'b0, st_err_warn = 1'b0;
  logic st_rx_empty;
  logic [7:0] err_set = '0, irq_set = '0;
  logic [7:0] rx_data, tx_data;
  logic rx_pop, tx_push, tx_en_o, irq_o;
  logic [2:0] mode_o;
  logic [7:0] int_en_o;

  logic [7:0] rxq [0:31];
  logic [7:0] txq [0:31];
  int rx_wr = 0, rx_rd = 0, tx_cnt = 0;
  logic [7:0] tx_b [0:17];
  logic [7:0] rx_b [0:17];
  int n_chk = 0, n_err = 0;
  logic [7:0] m_ctl0, m_ctl1, m_ien, rd;

  always #4 clk = ~clk;

  assign rx_data     = rxq[rx_rd & 31];
  assign st_rx_empty = (rx_rd == rx_wr);

  always @(posedge clk) begin
    if (rx_pop) rx_rd <= rx_rd + 1;
    if (tx_push) begin
      txq[tx_cnt & 31] <= tx_data;
      tx_cnt <= tx_cnt + 1;
    end
  end

  spi_cmd_regif u_spi_cmd_regif (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .st_tx_empty(st_tx_empty), .st_rx_empty(st_rx_empty),
    .st_bus_off(st_bus_off), .st_err_pass(st_err_pass), .st_err_warn(st_err_warn),
    .err_set(err_set), .irq_set(irq_set), .rx_data(rx_data), .rx_pop(rx_pop),
    .tx_data(tx_data), .tx_push(tx_push), .mode_o(mode_o), .tx_en_o(tx_en_o),
    .int_en_o(int_en_o), .irq_o(irq_o)
  );

  function automatic logic [7:0] exp_status(input logic txe, rxe, boff, epas, ewarn);
    return {txe, 2'b00, ewarn, epas, boff, rxe, 1'b0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Mode 0 master: drive MOSI while SCLK low, sample MISO just before the rising edge
  task automatic spi_xfer(input int nb, input int stop_bits);
    int sent = 0;
    for (int b = 0; b < 18; b++) rx_b[b] = 8'h00;
    @(negedge clk);
    spi_cs_n = 1'b0;
    wait_clk(HALF);
    for (int b = 0; b < nb; b++) begin
      for (int i = 7; i >= 0; i--) begin
        if (stop_bits >= 0 && sent == stop_bits) break;
        spi_mosi = tx_b[b][i];
        wait_clk(HALF);
        rx_b[b][i] = spi_miso;
        spi_sclk = 1'b1;
        wait_clk(HALF);
        spi_sclk = 1'b0;
        sent++;
      end
    end
    wait_clk(HALF);
    spi_cs_n = 1'b1;
    spi_mosi = 1'b0;
    wait_clk(3 * HALF);
  endtask

  task automatic reg_wr(input logic [7:0] op, input logic [7:0] v);
    tx_b[0] = op; tx_b[1] = v;
    spi_xfer(2, -1);
  endtask

  task automatic reg_rd(input logic [7:0] op, output logic [7:0] v);
    tx_b[0] = op; tx_b[1] = 8'h00;
    spi_xfer(2, -1);
    v = rx_b[1];
  endtask

  task automatic pulse_err(input logic [7:0] v);
    @(negedge clk); err_set = v;
    @(negedge clk); err_set = 8'h00;
  endtask

  task automatic pulse_irq(input logic [7:0] v);
    @(negedge clk); irq_set = v;
    @(negedge clk); irq_set = 8'h00;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int sav;
    void'($urandom(32'd20240611));
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);

    // R1 reset state at the ports and through reads
    check("R1 mode", mode_o, 3'd4);
    check("R1 tx_en", tx_en_o, 1'b0);
    check("R1 int_en", int_en_o, 8'h00);
    check("R1 irq", irq_o, 1'b0);
    check("R11 miso idle", spi_miso, 1'b0);
    reg_rd(8'hD2, rd); check("R1 ctl0 read", rd, 8'h80);
    reg_rd(8'hD4, rd); check("R1 ctl1 read", rd, 8'h00);
    reg_rd(8'hE2, rd); check("R1 R3 status idle", rd, 8'h82);
    m_ctl0 = 8'h80; m_ctl1 = 8'h00; m_ien = 8'h00;

    // R2 R3 random register traffic and status patterns
    for (int it = 0; it < 24; it++) begin
      logic [7:0] v;
      int sel;
      v = 8'($urandom);
      sel = $urandom % 3;
      if (sel == 0) begin reg_wr(8'h14, v); m_ctl0 = v; end
      else if (sel == 1) begin reg_wr(8'h16, v); m_ctl1 = v; end
      else begin reg_wr(8'h1C, v); m_ien = v; end
      check("R2 mode_o", mode_o, m_ctl0[7:5]);
      check("R2 tx_en_o", tx_en_o, m_ctl1[7]);
      check("R2 int_en_o", int_en_o, m_ien);
      reg_rd(8'hD2, rd); check("R3 ctl0 read", rd, m_ctl0);
      reg_rd(8'hD4, rd); check("R3 ctl1 read", rd, m_ctl1);
      @(negedge clk);
      st_tx_empty = 1'($urandom); st_bus_off = 1'($urandom);
      st_err_pass = 1'($urandom); st_err_warn = 1'($urandom);
      reg_rd(8'hE2, rd);
      check("R3 status", rd, exp_status(st_tx_empty, 1'b1, st_bus_off, st_err_pass, st_err_warn));
    end
    st_tx_empty = 1'b1; st_bus_off = 1'b0; st_err_pass = 1'b0; st_err_warn = 1'b0;

    // R5 sticky error flags, read-to-clear
    reg_rd(8'hDC, rd);
    pulse_err(8'h15);
    pulse_err(8'h40);
    reg_rd(8'hDC, rd); check("R5 err read", rd, 8'h55);
    reg_rd(8'hDC, rd); check("R5 err cleared", rd, 8'h00);

    // R6 interrupt flags and masking
    reg_wr(8'h1C, 8'h20); m_ien = 8'h20;
    reg_rd(8'hDE, rd);
    pulse_irq(8'h04);
    wait_clk(2); check("R6 masked irq low", irq_o, 1'b0);
    pulse_irq(8'h20);
    wait_clk(2); check("R6 irq high", irq_o, 1'b1);
    reg_rd(8'hDE, rd); check("R6 flags read", rd, 8'h24);
    check("R6 irq after clear", irq_o, 1'b0);
    reg_rd(8'hDE, rd); check("R6 flags cleared", rd, 8'h00);

    // R4 master reset keeps error flags
    reg_wr(8'h14, 8'h20); reg_wr(8'h16, 8'h80); reg_wr(8'h1C, 8'hFF);
    pulse_err(8'h80); pulse_irq(8'h01);
    tx_b[0] = 8'h56; spi_xfer(1, -1);
    check("R4 mode", mode_o, 3'd4);
    check("R4 tx_en", tx_en_o, 1'b0);
    check("R4 int_en", int_en_o, 8'h00);
    reg_rd(8'hD2, rd); check("R4 ctl0", rd, 8'h80);
    reg_rd(8'hDE, rd); check("R4 iflags cleared", rd, 8'h00);
    reg_rd(8'hDC, rd); check("R4 err kept", rd, 8'h80);
    m_ctl0 = 8'h80; m_ctl1 = 8'h00; m_ien = 8'h00;

    // R9 aborts four bits into the data byte
    tx_b[0] = 8'h16; tx_b[1] = 8'h80; spi_xfer(2, 12);
    check("R9 aborted write", tx_en_o, 1'b0);
    reg_rd(8'hD4, rd); check("R9 ctl1 unchanged", rd, 8'h00);
    pulse_err(8'h02);
    tx_b[0] = 8'hDC; tx_b[1] = 8'h00; spi_xfer(2, 12);
    reg_rd(8'hDC, rd); check("R9 aborted read keeps flags", rd, 8'h02);

    // R10 unknown opcode
    sav = rx_rd;
    tx_b[0] = 8'hAA; tx_b[1] = 8'hFF; tx_b[2] = 8'h55; spi_xfer(3, -1);
    check("R10 reply byte1", rx_b[1], 8'h00);
    check("R10 reply byte2", rx_b[2], 8'h00);
    reg_rd(8'hD2, rd); check("R10 ctl0 unchanged", rd, 8'h80);
    check("R10 int_en unchanged", int_en_o, 8'h00);
    check("R10 no pops", rx_rd, sav);
    check("R10 no pushes", tx_cnt, 0);

    // R7 receive burst: 16 queued, first burst stops at 14
    for (int i = 0; i < 16; i++) rxq[i] = 8'($urandom);
    rx_wr = 16;
    tx_b[0] = 8'h48;
    for (int i = 1; i < 18; i++) tx_b[i] = 8'h00;
    spi_xfer(17, -1);
    for (int i = 1; i <= 14; i++) check("R7 rx byte", rx_b[i], rxq[i-1]);
    check("R7 beyond limit", {rx_b[15], rx_b[16]}, 16'h0000);
    check("R7 pop count at limit", rx_rd, 14);
    spi_xfer(5, -1);
    check("R7 tail byte a", rx_b[1], rxq[14]);
    check("R7 tail byte b", rx_b[2], rxq[15]);
    check("R7 empty reads zero", {rx_b[3], rx_b[4]}, 16'h0000);
    check("R7 no pop when empty", rx_rd, 16);

    // R8 transmit burst of 16 data bytes
    tx_b[0] = 8'h12;
    for (int i = 1; i <= 16; i++) tx_b[i] = 8'($urandom);
    spi_xfer(17, -1);
    check("R8 push count", tx_cnt, 14);
    for (int i = 0; i < 14; i++) check("R8 tx byte", txq[i], tx_b[i+1]);

    // R11 idle line after traffic
    check("R11 miso idle after", spi_miso, 1'b0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule